// File: doc/BRIEF.md
# Multi-Channel Conversion Trigger Controller

This block holds one pending-conversion flag per logical converter channel, 64 channels by default. A 2-bit trigger kind per channel decides what raises its flag:
- a software strobe alone;
- a software strobe or a rising edge on the channel's own hardware line;
- the end of conversion of the channel just below it;
- the idle condition of the whole converter.

An arbiter elsewhere reads the flag vector and picks the next channel. When a conversion ends, the converter reports which channel finished, and this block clears that flag.

Chained channels form groups. A group starts on its first channel, and each later member becomes pending when its predecessor finishes while still pending. Idle-kind channels become pending together in the cycle after no channel is pending with its data protection off. Hardware lines are asynchronous. Each one passes through a synchronizer before its edge is taken.

Top module: `conv_trig_ctrl`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, every pending flag and every synchronizer and edge-history bit is cleared. A hardware line held high across reset therefore gives one edge after reset.
- R2: Kind 2'b00 (software only): a 1 on `sw_trig_i[n]` sets `pend_o[n]` at that clock edge. Activity on `hw_trig_i[n]` has no effect on the flag.
- R3: Kind 2'b01 (software or hardware): a 1 on `sw_trig_i[n]` sets `pend_o[n]` at that clock edge.
- R4: Kind 2'b01: when `hw_trig_i[n]` goes from 0 to 1 before clock edge E1, `pend_o[n]` reads 1 after edge E3 and not before. A line that stays high triggers no further sets.
- R5: Kind 2'b10 (chained): a completion of channel n-1 while `pend_o[n-1]` is 1 sets `pend_o[n]`. The same edge clears `pend_o[n-1]`.
- R6: Kind 2'b10: a completion of channel n-1 while `pend_o[n-1]` is 0 leaves `pend_o[n]` unchanged.
- R7: Channel 0 of kind 2'b10 never becomes pending. A completion of the highest channel sets no flag.
- R8: Kind 2'b11 (idle): at any edge where no channel has both its pending flag at 1 and its protect bit at 0, every idle-kind flag is set at once.
- R9: A pending channel whose `prot_i` bit is 1 does not block the idle condition. A pending channel with `prot_i` at 0 blocks it.
- R10: A 1 on `done_i` with index `done_ch_i` = n clears `pend_o[n]` when nothing sets it in the same cycle.
- R11: When a set and a completion clear hit the same channel in one cycle, the flag ends at 1.
- R12: `sw_trig_i[n]` has no effect on channels of kind 2'b10 or 2'b11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| kind_i | input | 2*NUM_CH | Trigger kind per channel; channel n uses bits [2n+1:2n] |
| sw_trig_i | input | NUM_CH | Software trigger strobes, one per channel |
| hw_trig_i | input | NUM_CH | Asynchronous hardware trigger lines |
| prot_i | input | NUM_CH | Data protection active, per channel |
| done_i | input | 1 | Conversion-complete strobe |
| done_ch_i | input | $clog2(NUM_CH) | Index of the channel that completed |
| pend_o | output | NUM_CH | Pending flags |

## Verification
The assertions assume that `done_i` names only channels below NUM_CH. They also assume that kinds, strobes and protect bits are steady across each clock edge, which a synchronous host gives. The stimulus changes every input one nanosecond after a rising edge and always keeps the completion index in range. Hardware lines are checked through the synchronizer delay rather than by assertion. The bench holds a line high for several cycles to confirm that a steady level does not trigger again.

// File: rtl/conv_trig_pkg.sv
package conv_trig_pkg;

   typedef enum logic [1:0] {
      TK_SOFT  = 2'b00,
      TK_EITHER = 2'b01,
      TK_CHAIN = 2'b10,
      TK_IDLE  = 2'b11
   } trig_kind_e;

   localparam int unsigned KIND_W = 2;

   function automatic logic kind_takes_sw(trig_kind_e k);
      return (k == TK_SOFT) || (k == TK_EITHER);
   endfunction

endpackage

// File: rtl/conv_trig_sync.sv
module conv_trig_sync #(
   parameter int unsigned NUM_CH = 64,
   parameter int unsigned STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] line_i,
   output logic [NUM_CH-1:0] rise_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("conv_trig_sync: STAGES must be at least 2");
   end

   logic [NUM_CH-1:0] stg [STAGES];
   logic [NUM_CH-1:0] hist_q;

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk) begin
            if (!rst_n) stg[0] <= '0;
            else        stg[0] <= line_i;
         end
      end else begin : g_next
         always_ff @(posedge clk) begin
            if (!rst_n) stg[s] <= '0;
            else        stg[s] <= stg[s-1];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) hist_q <= '0;
      else        hist_q <= stg[STAGES-1];
   end

   assign rise_o = stg[STAGES-1] & ~hist_q;

endmodule

// File: rtl/conv_trig_src.sv
module conv_trig_src
   import conv_trig_pkg::*;
#(
   parameter int unsigned NUM_CH = 64,
   parameter int unsigned CH_W   = $clog2(NUM_CH)
) (
   input  logic [KIND_W*NUM_CH-1:0] kind_i,
   input  logic [NUM_CH-1:0]        sw_i,
   input  logic [NUM_CH-1:0]        rise_i,
   input  logic [NUM_CH-1:0]        pend_i,
   input  logic [NUM_CH-1:0]        prot_i,
   input  logic                     done_i,
   input  logic [CH_W-1:0]          done_ch_i,
   output logic [NUM_CH-1:0]        set_o
);

   logic idle_now;

   // Idle: no channel both pending and unprotected.
   assign idle_now = ~|(pend_i & ~prot_i);

   for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
      trig_kind_e kind;
      logic       chain_hit;

      assign kind = trig_kind_e'(kind_i[KIND_W*n +: KIND_W]);

      if (n == 0) begin : g_head
         assign chain_hit = 1'b0;
      end else begin : g_link
         assign chain_hit = done_i && (done_ch_i == CH_W'(n - 1)) && pend_i[n-1];
      end

      always_comb begin
         set_o[n] = 1'b0;
         unique case (kind)
            TK_SOFT:   set_o[n] = sw_i[n];
            TK_EITHER: set_o[n] = sw_i[n] | rise_i[n];
            TK_CHAIN:  set_o[n] = chain_hit;
            TK_IDLE:   set_o[n] = idle_now;
            default:   set_o[n] = 1'b0;
         endcase
      end
   end

endmodule

// File: rtl/conv_trig_flags.sv
module conv_trig_flags #(
   parameter int unsigned NUM_CH = 64,
   parameter int unsigned CH_W   = $clog2(NUM_CH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] set_i,
   input  logic              done_i,
   input  logic [CH_W-1:0]   done_ch_i,
   output logic [NUM_CH-1:0] pend_o
);

   logic [NUM_CH-1:0] clr;
   logic [NUM_CH-1:0] pend_q;

   for (genvar n = 0; n < NUM_CH; n++) begin : g_bit
      assign clr[n] = done_i && (done_ch_i == CH_W'(n));

      always_ff @(posedge clk) begin
         if (!rst_n)        pend_q[n] <= 1'b0;
         else if (set_i[n]) pend_q[n] <= 1'b1;
         else if (clr[n])   pend_q[n] <= 1'b0;
      end
   end

   assign pend_o = pend_q;

endmodule

// File: rtl/conv_trig_ctrl.sv
module conv_trig_ctrl
   import conv_trig_pkg::*;
#(
   parameter int unsigned NUM_CH      = 64,
   parameter int unsigned SYNC_STAGES = 2,
   localparam int unsigned CH_W       = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [KIND_W*NUM_CH-1:0] kind_i,
   input  logic [NUM_CH-1:0]        sw_trig_i,
   input  logic [NUM_CH-1:0]        hw_trig_i,
   input  logic [NUM_CH-1:0]        prot_i,
   input  logic                     done_i,
   input  logic [CH_W-1:0]          done_ch_i,
   output logic [NUM_CH-1:0]        pend_o
);

   if (NUM_CH < 2) begin : g_bad_ch
      $error("conv_trig_ctrl: NUM_CH must be at least 2");
   end

   logic [NUM_CH-1:0] rise;
   logic [NUM_CH-1:0] set_req;
   logic [NUM_CH-1:0] pend;

   conv_trig_sync #(.NUM_CH(NUM_CH), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .line_i(hw_trig_i),
      .rise_o(rise)
   );

   conv_trig_src #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_src (
      .kind_i   (kind_i),
      .sw_i     (sw_trig_i),
      .rise_i   (rise),
      .pend_i   (pend),
      .prot_i   (prot_i),
      .done_i   (done_i),
      .done_ch_i(done_ch_i),
      .set_o    (set_req)
   );

   conv_trig_flags #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_flags (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_i    (set_req),
      .done_i   (done_i),
      .done_ch_i(done_ch_i),
      .pend_o   (pend)
   );

   assign pend_o = pend;

endmodule

module conv_trig_chk #(
   parameter int unsigned NUM_CH = 64,
   parameter int unsigned CH_W   = 6
) (
   input logic                clk,
   input logic                rst_n,
   input logic [2*NUM_CH-1:0] kind_i,
   input logic [NUM_CH-1:0]   sw_trig_i,
   input logic [NUM_CH-1:0]   prot_i,
   input logic                done_i,
   input logic [CH_W-1:0]     done_ch_i,
   input logic [NUM_CH-1:0]   pend_o
);

   for (genvar n = 0; n < NUM_CH; n++) begin : g_c
      // R2 R3 R11
      sw_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (sw_trig_i[n] && !kind_i[2*n+1]) |=> pend_o[n]);

      // R10
      done_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (done_i && done_ch_i == CH_W'(n) && kind_i[2*n +: 2] == 2'b00 && !sw_trig_i[n])
         |=> !pend_o[n]);

      // R8
      idle_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (kind_i[2*n +: 2] == 2'b11 && ((pend_o & ~prot_i) == '0)) |=> pend_o[n]);

      if (n == 0) begin : g_h
         // R7
         head_chain_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!pend_o[0] && kind_i[1:0] == 2'b10) |=> !pend_o[0]);
      end else begin : g_l
         // R5
         chain_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (done_i && done_ch_i == CH_W'(n-1) && pend_o[n-1] && kind_i[2*n +: 2] == 2'b10)
            |=> pend_o[n]);
      end
   end

endmodule

bind conv_trig_ctrl conv_trig_chk #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .kind_i   (kind_i),
   .sw_trig_i(sw_trig_i),
   .prot_i   (prot_i),
   .done_i   (done_i),
   .done_ch_i(done_ch_i),
   .pend_o   (pend_o)
);

// File: tb/test_conv_trig_ctrl.sv
module test_conv_trig_ctrl;
   localparam int N  = 64;
   localparam int CW = 6;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [2*N-1:0]  kind_i = '0;
   logic [N-1:0]    sw_trig_i = '0;
   logic [N-1:0]    hw_trig_i = '0;
   logic [N-1:0]    prot_i = '0;
   logic            done_i = 1'b0;
   logic [CW-1:0]   done_ch_i = '0;
   logic [N-1:0]    pend_o;

   int errors = 0;
   int checks = 0;
   bit finished = 0;

   // reference model state
   bit m_pend [N];
   bit m_s1 [N];
   bit m_s2 [N];
   bit m_prev [N];

   always #2.5 clk = ~clk;

   conv_trig_ctrl #(.NUM_CH(N)) i_conv_trig_ctrl (
      .clk(clk), .rst_n(rst_n), .kind_i(kind_i), .sw_trig_i(sw_trig_i),
      .hw_trig_i(hw_trig_i), .prot_i(prot_i), .done_i(done_i),
      .done_ch_i(done_ch_i), .pend_o(pend_o)
   );

   task automatic model_step();
      bit nxt [N];
      bit busy = 0;
      for (int i = 0; i < N; i++) if (m_pend[i] && !prot_i[i]) busy = 1;
      for (int i = 0; i < N; i++) begin
         int k = kind_i[2*i +: 2];
         bit edge_seen = m_s2[i] && !m_prev[i];
         bit s = 0;
         if (!rst_n) begin nxt[i] = 0; continue; end
         if ((k == 0 || k == 1) && sw_trig_i[i]) s = 1;
         if (k == 1 && edge_seen) s = 1;
         if (k == 2 && i > 0 && done_i && int'(done_ch_i) == i - 1 && m_pend[i-1]) s = 1;
         if (k == 3 && !busy) s = 1;
         if (s) nxt[i] = 1;
         else if (done_i && int'(done_ch_i) == i) nxt[i] = 0;
         else nxt[i] = m_pend[i];
      end
      for (int i = 0; i < N; i++) begin
         m_pend[i] = nxt[i];
         if (!rst_n) begin
            m_prev[i] = 0; m_s2[i] = 0; m_s1[i] = 0;
         end else begin
            m_prev[i] = m_s2[i]; m_s2[i] = m_s1[i]; m_s1[i] = hw_trig_i[i];
         end
      end
   endtask

   task automatic chk(string req, bit act, bit exp_v, string what);
      checks++;
      if (act !== exp_v) begin
         errors++;
         $display("FAIL %s %s: actual=%0b expected=%0b", req, what, act, exp_v);
      end
   endtask

   task automatic tick(string req);
      @(posedge clk);
      model_step();
      #1;
      for (int i = 0; i < N; i++) begin
         checks++;
         if (pend_o[i] !== m_pend[i]) begin
            errors++;
            $display("FAIL %s model ch%0d: actual=%0b expected=%0b", req, i, pend_o[i], m_pend[i]);
         end
      end
   endtask

   task automatic set_kind(int ch, logic [1:0] k);
      kind_i[2*ch +: 2] = k;
   endtask

   task automatic done_on(int ch);
      done_i = 1'b1; done_ch_i = CW'(ch);
   endtask

   task automatic quiet();
      sw_trig_i = '0; done_i = 1'b0;
   endtask

   initial begin
      for (int i = 0; i < N; i++) begin
         m_pend[i] = 0; m_s1[i] = 0; m_s2[i] = 0; m_prev[i] = 0;
      end
      hw_trig_i[3] = 1'b1;
      #1;
      tick("R1"); tick("R1");
      chk("R1", pend_o == '0, 1'b1, "all clear after reset");
      rst_n = 1'b1;

      // R1: line 3 high across reset gives one edge; channel 3 kind 01
      set_kind(3, 2'b01);
      tick("R1"); tick("R1");
      chk("R1", pend_o[3], 1'b0, "before sync delay");
      tick("R1");
      chk("R1", pend_o[3], 1'b1, "edge after reset");
      done_on(3); tick("R10"); quiet();
      chk("R10", pend_o[3], 1'b0, "cleared by done");
      hw_trig_i[3] = 1'b0;

      // R2: software-only channel
      sw_trig_i[5] = 1'b1; tick("R2"); quiet();
      chk("R2", pend_o[5], 1'b1, "sw sets kind 00");
      done_on(5); tick("R10"); quiet();
      hw_trig_i[5] = 1'b1;
      repeat (5) tick("R2");
      chk("R2", pend_o[5], 1'b0, "hw ignored on kind 00");
      hw_trig_i[5] = 1'b0;

      // R3 / R4
      set_kind(7, 2'b01);
      sw_trig_i[7] = 1'b1; tick("R3"); quiet();
      chk("R3", pend_o[7], 1'b1, "sw sets kind 01");
      done_on(7); tick("R10"); quiet();
      hw_trig_i[7] = 1'b1;
      tick("R4"); tick("R4");
      chk("R4", pend_o[7], 1'b0, "not before third edge");
      tick("R4");
      chk("R4", pend_o[7], 1'b1, "set on third edge");
      done_on(7); tick("R4"); quiet();
      repeat (4) tick("R4");
      chk("R4", pend_o[7], 1'b0, "steady level no retrigger");
      hw_trig_i[7] = 1'b0;

      // R5 / R6 chain 10 -> 11 -> 12
      set_kind(11, 2'b10); set_kind(12, 2'b10);
      sw_trig_i[10] = 1'b1; tick("R5"); quiet();
      done_on(10); tick("R5"); quiet();
      chk("R5", pend_o[11], 1'b1, "successor set");
      chk("R5", pend_o[10], 1'b0, "finisher cleared");
      done_on(11); tick("R5"); quiet();
      chk("R5", pend_o[12], 1'b1, "second link");
      done_on(12); tick("R10"); quiet();
      done_on(11); tick("R6"); quiet();
      chk("R6", pend_o[12], 1'b0, "no chain from idle predecessor");

      // R7
      set_kind(0, 2'b10);
      sw_trig_i[63] = 1'b1; tick("R7"); quiet();
      done_on(63); tick("R7"); quiet();
      chk("R7", pend_o[0], 1'b0, "no wrap to channel 0");
      chk("R7", pend_o[63], 1'b0, "last cleared");
      done_on(0); tick("R7"); quiet();
      chk("R7", pend_o[1], 1'b0, "nothing chained");

      // R11
      sw_trig_i[20] = 1'b1; tick("R11"); done_on(20); tick("R11"); quiet();
      chk("R11", pend_o[20], 1'b1, "set wins over clear");

      // R12 and R8/R9
      set_kind(30, 2'b10);
      sw_trig_i[30] = 1'b1; tick("R12"); quiet();
      chk("R12", pend_o[30], 1'b0, "sw ignored on kind 10");
      set_kind(41, 2'b11); set_kind(42, 2'b11);
      sw_trig_i[41] = 1'b1; tick("R12"); quiet();
      chk("R12", pend_o[41], 1'b0, "sw ignored on kind 11 while busy");
      prot_i[20] = 1'b1; tick("R9");
      chk("R9", pend_o[41] & pend_o[42], 1'b1, "protected pending does not block idle");
      prot_i[20] = 1'b0;
      done_on(41); tick("R8"); quiet();
      done_on(42); tick("R8"); quiet();
      done_on(20); tick("R8"); quiet();
      chk("R8", pend_o[41] | pend_o[42], 1'b0, "unprotected pending blocks idle");
      tick("R8");
      chk("R8", pend_o[41] & pend_o[42], 1'b1, "idle channels set together");
      repeat (3) tick("R8");

      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         errors++; checks++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule